// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt

The block is an 8-bit down-counter that advances on one of four rate strobes taken from a 32.768 kHz reference chain: 4096 Hz, 64 Hz, 1 Hz and one pulse per minute. These strobes arrive as single-cycle inputs. Software writes a start value into the count register and enables the timer. On each strobe of the selected source the counter steps down by one. When it passes from one to zero it reloads the start value, sets a sticky timer flag, and can drive an active-low interrupt line.

The interrupt line works in one of two styles, picked by a control bit. In level style the line stays low while the flag and the interrupt enable are both set. In pulse style the line goes low at each expiry and stays low for exactly one period of the selected source, whatever the flag holds. Writes go through a simple strobe port (`wr_en`, `wr_addr`, `wr_data`). Reads are combinational on `rd_addr`. The three registers are: control 2 at 0x1, timer control at 0xE, and count at 0xF, directly after timer control.

The counter is a three-state machine on the current count. `T_EMPTY` means the count is 0. `T_LAST` means the count is 1. `T_COUNT` means the count is above 1. It moves from T_COUNT to T_COUNT or T_LAST when it decrements. It moves from T_LAST back to the reload state when it expires. A write of the count register takes it from any state to the state of the new value. The interrupt pulse machine has two states. It moves from `P_IDLE` to `P_LOW` on an expiry. It moves from `P_LOW` back to `P_IDLE` on the next selected strobe that is not itself an expiry, or when counting is disabled.

Top module: `cdt_top`

## Requirements
- R1: After reset, every register reads 0 and `irq_n` is high.
- R2: Timer control bit 7 enables counting. Bits 1:0 pick the source strobe: 0 = `src_tick[0]` (4096 Hz), 1 = `src_tick[1]` (64 Hz), 2 = `src_tick[2]` (1 Hz), 3 = `src_tick[3]` (1/60 Hz). Strobes of the sources that are not picked have no effect on the count.
- R3: The count register sits at address 0xF, right after timer control at 0xE. A write loads both the reload value and the running count. A read returns the running count.
- R4: Each picked strobe while enabled decrements a count above 1. A strobe at count 1 is an expiry: the count reloads from the last written value and control 2 bit 2 (timer flag) sets in the same cycle.
- R5: The timer flag is sticky. Writing control 2 with bit 2 = 0 clears it. Writing bit 2 = 1 leaves it unchanged. An expiry in the same cycle as a clearing write leaves it set.
- R6: With control 2 bit 4 = 0 (level style), `irq_n` is low exactly when the timer flag and control 2 bit 0 (interrupt enable) are both 1.
- R7: With control 2 bit 4 = 1 (pulse style) and bit 0 = 1, `irq_n` goes low after each expiry. It returns high after the next picked strobe that is not an expiry, or when counting is disabled. The flag value does not affect it.
- R8: A count of 0 never expires and never changes on strobes.
- R9: Clearing bit 7 freezes the count. Setting it again resumes counting from the frozen value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| src_tick | input | 4 | Single-cycle rate strobes, one per source |
| irq_n | output | 1 | Active-low timer interrupt |

## Verification
The bench targets the expiry step from 1 to reload. A design with an off-by-one error there expires one strobe late or early, or passes through a visible 0. It loads a count of 0 and applies strobes from every source; a design that wraps below zero starts expiring. It writes a flag clear in the same cycle as an expiry and writes a 1 to the flag bit; a design that gets either wrong loses or fakes an interrupt. In pulse style it checks that the low period lasts exactly until the next picked strobe and ignores the flag, and that strobes from the sources not picked and a disabled timer leave the count frozen.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;
    localparam int DATA_W = 8;
    localparam int NSRC   = 4;
    localparam int SEL_W  = $clog2(NSRC);

    localparam logic [3:0] A_CTL2 = 4'h1;
    localparam logic [3:0] A_TCTL = 4'hE;
    localparam logic [3:0] A_TCNT = 4'hF;

    localparam int B_TIE  = 0;
    localparam int B_TF   = 2;
    localparam int B_TITP = 4;
    localparam int B_EN   = 7;

    typedef enum logic [1:0] {
        T_EMPTY = 2'd0,
        T_LAST  = 2'd1,
        T_COUNT = 2'd2
    } cnt_state_e;

    typedef enum logic {
        P_IDLE = 1'b0,
        P_LOW  = 1'b1
    } pls_state_e;
endpackage

// File: rtl/cdt_src_sel.sv
`timescale 1ns/1ps
module cdt_src_sel #(
    parameter int NSRC  = 4,
    parameter int SEL_W = 2
) (
    input  logic [NSRC-1:0]  src_tick,
    input  logic [SEL_W-1:0] sel,
    input  logic             en,
    output logic             tick
);
    logic [NSRC-1:0] hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = src_tick[i] && (sel == SEL_W'(i));
    end

    assign tick = en && (|hit);
endmodule

// File: rtl/cdt_core.sv
`timescale 1ns/1ps
module cdt_core
    import cdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] rel_q, rel_d;
    logic             expire;

    always_comb begin
        cnt_d  = cnt_q;
        rel_d  = rel_q;
        expire = 1'b0;
        if (load) begin
            cnt_d = load_val;
            rel_d = load_val;
        end else begin
            unique case (state_q)
                T_EMPTY: cnt_d = cnt_q;
                T_COUNT: if (tick) cnt_d = cnt_q - ONE;
                T_LAST: begin
                    if (tick) begin
                        cnt_d  = rel_q;
                        expire = 1'b1;
                    end
                end
                default: cnt_d = cnt_q;
            endcase
        end
        if (cnt_d == '0)       state_d = T_EMPTY;
        else if (cnt_d == ONE) state_d = T_LAST;
        else                   state_d = T_COUNT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rel_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            rel_q <= rel_d;
        end
    end

    assign cnt_o    = cnt_q;
    assign expire_o = expire;

    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_EMPTY && !load) |=> (cnt_q == '0)); // R8
    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q)); // R9
    AST_LAST_IS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_LAST) |-> (cnt_q == ONE)); // R4
endmodule

// File: rtl/cdt_irq.sv
`timescale 1ns/1ps
module cdt_irq
    import cdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic tick,
    input  logic en,
    input  logic tf,
    input  logic tie,
    input  logic pulse_mode,
    output logic irq_n
);
    pls_state_e pst_q, pst_d;

    always_comb begin
        pst_d = pst_q;
        unique case (pst_q)
            P_IDLE: if (expire) pst_d = P_LOW;
            P_LOW: begin
                if (expire)         pst_d = P_LOW;
                else if (tick || !en) pst_d = P_IDLE;
            end
            default: pst_d = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pst_q <= P_IDLE;
        else        pst_q <= pst_d;
    end

    always_comb begin
        if (pulse_mode) irq_n = !(tie && (pst_q == P_LOW));
        else            irq_n = !(tie && tf);
    end

    AST_NO_SPURIOUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (pst_q == P_IDLE && !expire) |=> (pst_q == P_IDLE)); // R7
    AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (pst_q == P_LOW)); // R7
endmodule

// File: rtl/cdt_top.sv
`timescale 1ns/1ps
module cdt_top
    import cdt_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic [3:0]        src_tick,
    output logic              irq_n
);
    localparam logic [ADDR_W-1:0] AD_CTL2 = ADDR_W'(A_CTL2);
    localparam logic [ADDR_W-1:0] AD_TCTL = ADDR_W'(A_TCTL);
    localparam logic [ADDR_W-1:0] AD_TCNT = ADDR_W'(A_TCNT);

    logic             en_q, tf_q, tie_q, titp_q;
    logic [SEL_W-1:0] sel_q;
    logic             wr_ctl2, wr_tctl, wr_tcnt;
    logic             tick, expire;
    logic [CNT_W-1:0] cnt;

    assign wr_ctl2 = wr_en && (wr_addr == AD_CTL2);
    assign wr_tctl = wr_en && (wr_addr == AD_TCTL);
    assign wr_tcnt = wr_en && (wr_addr == AD_TCNT);

    cdt_src_sel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_sel (
        .src_tick (src_tick),
        .sel      (sel_q),
        .en       (en_q),
        .tick     (tick)
    );

    cdt_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (wr_tcnt),
        .load_val (wr_data[CNT_W-1:0]),
        .cnt_o    (cnt),
        .expire_o (expire)
    );

    cdt_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .tick       (tick),
        .en         (en_q),
        .tf         (tf_q),
        .tie        (tie_q),
        .pulse_mode (titp_q),
        .irq_n      (irq_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            sel_q  <= '0;
            tie_q  <= 1'b0;
            titp_q <= 1'b0;
        end else begin
            if (wr_tctl) begin
                en_q  <= wr_data[B_EN];
                sel_q <= wr_data[SEL_W-1:0];
            end
            if (wr_ctl2) begin
                tie_q  <= wr_data[B_TIE];
                titp_q <= wr_data[B_TITP];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         tf_q <= 1'b0;
        else if (expire)                    tf_q <= 1'b1;
        else if (wr_ctl2 && !wr_data[B_TF]) tf_q <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AD_CTL2) begin
            rd_data[B_TIE]  = tie_q;
            rd_data[B_TF]   = tf_q;
            rd_data[B_TITP] = titp_q;
        end else if (rd_addr == AD_TCTL) begin
            rd_data[B_EN]      = en_q;
            rd_data[SEL_W-1:0] = sel_q;
        end else if (rd_addr == AD_TCNT) begin
            rd_data = 8'(cnt);
        end
    end

    AST_TF_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> tf_q); // R4
    AST_TF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_q && !(wr_ctl2 && !wr_data[B_TF])) |=> tf_q); // R5
    AST_NO_EXPIRE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !expire); // R9
endmodule

// File: tb/cdt_top_tb.sv
`timescale 1ns/1ps
module cdt_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = 4'hF;
    logic [7:0] rd_data;
    logic [3:0] src_tick = '0;
    logic       irq_n;

    int checks = 0;
    int errors = 0;

    // bench model of the register-visible state
    int m_cnt = 0, m_rel = 0, m_sel = 0;
    bit m_en = 0, m_tf = 0, m_tie = 0, m_titp = 0, m_pls = 0;

    always #10 clk = ~clk;

    cdt_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .src_tick(src_tick), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_irq_n();
        return !(m_tie && (m_titp ? m_pls : m_tf));
    endfunction

    task automatic model_edge(input bit we, input logic [3:0] a,
                              input logic [7:0] d, input logic [3:0] tk);
        bit tick = m_en && tk[m_sel];
        bit ex = 0;
        if (we && a == 4'hF) begin
            m_cnt = d; m_rel = d;
        end else if (tick && m_cnt != 0) begin
            if (m_cnt == 1) begin m_cnt = m_rel; ex = 1; end
            else m_cnt = m_cnt - 1;
        end
        if (ex) m_pls = 1;
        else if (tick || !m_en) m_pls = 0;
        if (ex) m_tf = 1;
        else if (we && a == 4'h1 && !d[2]) m_tf = 0;
        if (we && a == 4'h1) begin m_tie = d[0]; m_titp = d[4]; end
        if (we && a == 4'hE) begin m_en = d[7]; m_sel = int'(d[1:0]); end
    endtask

    task automatic step(input bit we, input logic [3:0] a,
                        input logic [7:0] d, input logic [3:0] tk);
        wr_en = we; wr_addr = a; wr_data = d; src_tick = tk;
        @(posedge clk);
        model_edge(we, a, d, tk);
        @(negedge clk);
        wr_en = 0; src_tick = '0;
        rd_addr = 4'hF;
        #1;
        chk("R4", int'(rd_data), m_cnt);
        chk(m_titp ? "R7" : "R6", int'(irq_n), int'(exp_irq_n()));
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        rd_addr = a; #1; v = int'(rd_data); rd_addr = 4'hF; #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int seed;
        seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(4'h1, v); chk("R1", v, 0);
        rd(4'hE, v); chk("R1", v, 0);
        rd(4'hF, v); chk("R1", v, 0);
        chk("R1", int'(irq_n), 1);

        // R3 count load and readback
        step(1, 4'hF, 8'd5, 4'h0);
        rd(4'hF, v); chk("R3", v, 5);
        step(1, 4'hE, 8'h80, 4'h0);

        // R2 only the picked source counts
        for (int s = 1; s < 4; s++) step(0, 4'h0, 8'h0, 4'(1 << s));
        rd(4'hF, v); chk("R2", v, 5);
        step(0, 4'h0, 8'h0, 4'h1);
        rd(4'hF, v); chk("R2", v, 4);
        step(1, 4'hE, 8'h82, 4'h0);
        step(0, 4'h0, 8'h0, 4'h1);
        rd(4'hF, v); chk("R2", v, 4);
        step(0, 4'h0, 8'h0, 4'h4);
        rd(4'hF, v); chk("R2", v, 3);

        // R9 freeze and resume
        step(1, 4'hE, 8'h02, 4'h0);
        for (int k = 0; k < 4; k++) step(0, 4'h0, 8'h0, 4'hF);
        rd(4'hF, v); chk("R9", v, 3);
        step(1, 4'hE, 8'h82, 4'h0);
        step(0, 4'h0, 8'h0, 4'h4);
        rd(4'hF, v); chk("R9", v, 2);

        // R4 / R6 expiry, reload, level interrupt
        step(1, 4'h1, 8'h01, 4'h0);
        step(0, 4'h0, 8'h0, 4'h4);
        step(0, 4'h0, 8'h0, 4'h4);
        rd(4'hF, v); chk("R4", v, 5);
        rd(4'h1, v); chk("R4", (v >> 2) & 1, 1);
        chk("R6", int'(irq_n), 0);

        // R5 sticky flag
        step(1, 4'h1, 8'h05, 4'h0);
        rd(4'h1, v); chk("R5", (v >> 2) & 1, 1);
        step(1, 4'h1, 8'h01, 4'h0);
        rd(4'h1, v); chk("R5", (v >> 2) & 1, 0);
        chk("R6", int'(irq_n), 1);
        // clear in same cycle as expiry: flag stays set
        step(1, 4'hF, 8'd1, 4'h0);
        step(1, 4'h1, 8'h01, 4'h4);
        rd(4'h1, v); chk("R5", (v >> 2) & 1, 1);
        step(1, 4'h1, 8'h01, 4'h0);

        // R7 pulse style
        step(1, 4'h1, 8'h11, 4'h0);
        step(1, 4'hF, 8'd2, 4'h0);
        step(0, 4'h0, 8'h0, 4'h4);
        chk("R7", int'(irq_n), 1);
        step(0, 4'h0, 8'h0, 4'h4);
        chk("R7", int'(irq_n), 0);
        step(1, 4'h1, 8'h11, 4'h0);
        chk("R7", int'(irq_n), 0);
        step(0, 4'h0, 8'h0, 4'h0);
        chk("R7", int'(irq_n), 0);
        step(0, 4'h0, 8'h0, 4'h4);
        chk("R7", int'(irq_n), 1);

        // R8 zero count never expires
        step(1, 4'h1, 8'h01, 4'h0);
        step(1, 4'hF, 8'd0, 4'h0);
        for (int s = 0; s < 4; s++) begin
            step(1, 4'hE, 8'(8'h80 | s), 4'h0);
            for (int k = 0; k < 5; k++) step(0, 4'h0, 8'h0, 4'hF);
        end
        rd(4'hF, v); chk("R8", v, 0);
        rd(4'h1, v); chk("R8", (v >> 2) & 1, 0);
        chk("R8", int'(irq_n), 1);

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] tk;
            bit we;
            logic [3:0] a;
            logic [7:0] d;
            for (int b = 0; b < 4; b++) tk[b] = ($urandom % 4) == 0;
            we = ($urandom % 12) == 0;
            case ($urandom % 3)
                0: a = 4'h1;
                1: a = 4'hE;
                default: a = 4'hF;
            endcase
            d = 8'($urandom);
            if (a == 4'hF) d = 8'($urandom % 6);
            if (a == 4'hE && ($urandom % 4) != 0) d[7] = 1'b1;
            if (a == 4'h1) d[0] = ($urandom % 4) != 0;
            step(we, a, d, tk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule